// File: doc/BRIEF.md
# DMA Block Counter with Auto-Reinitialization

This block keeps the transfer counts for a six-channel DMA engine and re-arms each channel when a block ends. Every channel has working registers (source address, destination address, element count, frame count) and a shadow reload set that the CPU may fill while the current block is still running. The bus engine reports each element through a read-done strobe and a write-done strobe. The block counts elements and frames, marks frame and block boundaries with one-cycle pulses, and at the end of a block either reloads the working registers and continues, or drops the channel's enable.

A single control word holds the channel enables and a select bit. With the select bit clear, every channel draws its reload values from the reload set of channel 0. With it set, each channel draws from its own set. The strobes are single-cycle event pulses from the bus engine and are plain signals without back-pressure. A strobe that arrives while the block cannot act on it is dropped. CPU writes go through a one-cycle write port and are always accepted.

Top module: `dma_autoinit_counter`

## Requirements
- R1: After reset, every working register, reload register, autoinit flag and the control word read 0, and no pulse is active.
- R2: A CPU write (`cpu_we`) stores `cpu_wdata` into the field chosen by `cpu_fld` of channel `cpu_ch`, at the next edge. Field codes: 0 source, 1 destination, 2 element count, 3 frame count (low 8 bits), 4 reload source, 5 reload destination, 6 reload element count, 7 reload frame count, 8 autoinit flag (bit 0), 9 control word (`cpu_ch` ignored).
- R3: On an accepted read strobe, a nonzero element count decrements by one. A count of N gives N+1 reads per frame. A read is accepted when the channel is enabled and is not waiting for its final write.
- R4: An accepted read at element count 0 raises `frame_done_o` for one cycle, starting the next cycle. If the frame count is nonzero, it decrements and the element count returns to the last value loaded into the working element count.
- R5: An accepted read at element count 0 and frame count 0 makes the channel wait. Reads are ignored while it waits. The next write strobe ends the block and raises `block_done_o` for one cycle, starting the next cycle.
- R6: A write strobe is ignored on a channel that is not waiting. Both strobes are ignored on a disabled channel.
- R7: At block end with autoinit set, all four working registers load from the selected reload set. The channel stays enabled, and the next accepted read counts the new block.
- R8: At block end with autoinit clear, the channel's enable bit is cleared, even against a control write in the same cycle. The counters keep their values.
- R9: Control bit 14 selects the reload source. A value of 0 (the reset value) selects channel 0's set for every channel. A value of 1 gives each channel its own set.
- R10: Writes to reload registers never change the working registers or the counting of the current block.
- R11: If a reload register write and a block end that reads that same register fall in one cycle, the reload takes the value being written.
- R12: A CPU write to a working register wins over a counter update on that register in the same cycle.
- R13: Control bits 5:0 are the channel enables. Bits 15, 13:8 and 7:6 are stored and read back on `ctrl_o` without affecting the counting.
- R14: Element count 0xFFFF gives a frame of 65536 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_ch | input | 3 | Target channel of the write |
| cpu_fld | input | 4 | Field code (see R2) |
| cpu_wdata | input | 16 | Write data |
| rd_done | input | NCH | Per-channel element read-done strobes |
| wr_done | input | NCH | Per-channel element write-done strobes |
| ctrl_o | output | 16 | Control word |
| src_o | output | NCH*16 | Working source addresses, channel c at [16c+15:16c] |
| dst_o | output | NCH*16 | Working destination addresses |
| elem_o | output | NCH*16 | Working element counts |
| frame_o | output | NCH*8 | Working frame counts |
| frame_done_o | output | NCH | One-cycle frame-end pulses |
| block_done_o | output | NCH | One-cycle block-end pulses |

## Verification
The bench builds the block with its default of six channels. This lets one run mix shared-set and private-set reloads across channels whose sets hold different values, so that a wrong set index becomes visible. The 16-bit count width is kept at full size, so a single run can carry a 65536-read frame. Long random stretches then exercise same-cycle collisions between CPU writes, read strobes and block ends on all six channels together.

// File: rtl/dma_ai_pkg.sv
package dma_ai_pkg;
  localparam int DW  = 16;
  localparam int AW  = 16;
  localparam int CW  = 16;
  localparam int FW  = 8;
  localparam int SEL_BIT = 14;

  typedef enum logic [3:0] {
    F_SRC  = 4'd0,
    F_DST  = 4'd1,
    F_CNT  = 4'd2,
    F_FRM  = 4'd3,
    F_RSRC = 4'd4,
    F_RDST = 4'd5,
    F_RCNT = 4'd6,
    F_RFRM = 4'd7,
    F_AUTO = 4'd8,
    F_CTRL = 4'd9
  } field_e;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [CW-1:0] cnt;
    logic [FW-1:0] frm;
  } rld_t;
endpackage

// File: rtl/dma_ai_reload_bank.sv
module dma_ai_reload_bank
  import dma_ai_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CHW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_we,
  input  logic [CHW-1:0]       cpu_ch,
  input  logic [3:0]           cpu_fld,
  input  logic [DW-1:0]        cpu_wdata,
  input  logic                 own_set,
  output rld_t [NCH-1:0]       sel_rld
);
  rld_t bank [NCH];
  logic ch_ok;

  assign ch_ok = cpu_we && (int'(cpu_ch) < NCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) bank[i] <= '0;
    end else if (ch_ok) begin
      case (cpu_fld)
        4'(F_RSRC): bank[cpu_ch].src <= cpu_wdata[AW-1:0];
        4'(F_RDST): bank[cpu_ch].dst <= cpu_wdata[AW-1:0];
        4'(F_RCNT): bank[cpu_ch].cnt <= cpu_wdata[CW-1:0];
        4'(F_RFRM): bank[cpu_ch].frm <= cpu_wdata[FW-1:0];
        default: ;
      endcase
    end
  end

  // each channel sees either set 0 or its own set, with same-cycle write bypass
  for (genvar c = 0; c < NCH; c++) begin : g_sel
    logic [CHW-1:0] idx;
    rld_t           v;
    always_comb begin
      idx = own_set ? CHW'(c) : '0;
      v   = bank[idx];
      if (cpu_we && cpu_ch == idx) begin
        case (cpu_fld)
          4'(F_RSRC): v.src = cpu_wdata[AW-1:0];
          4'(F_RDST): v.dst = cpu_wdata[AW-1:0];
          4'(F_RCNT): v.cnt = cpu_wdata[CW-1:0];
          4'(F_RFRM): v.frm = cpu_wdata[FW-1:0];
          default: ;
        endcase
      end
      sel_rld[c] = v;
    end
  end
endmodule

// File: rtl/dma_ai_chan.sv
module dma_ai_chan
  import dma_ai_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rd_done,
  input  logic          wr_done,
  input  logic          we_src,
  input  logic          we_dst,
  input  logic          we_cnt,
  input  logic          we_frm,
  input  logic          we_ai,
  input  logic [DW-1:0] wdata,
  input  rld_t          rld,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] elem_q,
  output logic [FW-1:0] frm_q,
  output logic          frame_done_q,
  output logic          block_done_q,
  output logic          end_evt,
  output logic          autoinit_q,
  output logic          pend_q
);
  logic [CW-1:0] init_q;
  logic          rd_take;

  assign end_evt = en && pend_q && wr_done;
  assign rd_take = en && !pend_q && rd_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q        <= '0;
      dst_q        <= '0;
      elem_q       <= '0;
      init_q       <= '0;
      frm_q        <= '0;
      frame_done_q <= 1'b0;
      block_done_q <= 1'b0;
      autoinit_q   <= 1'b0;
      pend_q       <= 1'b0;
    end else begin
      frame_done_q <= 1'b0;
      block_done_q <= 1'b0;
      if (end_evt) begin
        pend_q       <= 1'b0;
        block_done_q <= 1'b1;
        if (autoinit_q) begin
          src_q  <= rld.src;
          dst_q  <= rld.dst;
          elem_q <= rld.cnt;
          init_q <= rld.cnt;
          frm_q  <= rld.frm;
        end
      end else if (rd_take) begin
        if (elem_q != '0) begin
          elem_q <= elem_q - 1'b1;
        end else begin
          frame_done_q <= 1'b1;
          if (frm_q != '0) begin
            frm_q  <= frm_q - 1'b1;
            elem_q <= init_q;
          end else begin
            pend_q <= 1'b1;
          end
        end
      end
      // CPU writes take precedence over the counter updates above
      if (we_src) src_q <= wdata[AW-1:0];
      if (we_dst) dst_q <= wdata[AW-1:0];
      if (we_cnt) begin
        elem_q <= wdata[CW-1:0];
        init_q <= wdata[CW-1:0];
      end
      if (we_frm) frm_q <= wdata[FW-1:0];
      if (we_ai)  autoinit_q <= wdata[0];
    end
  end
endmodule

// File: rtl/dma_ai_ctrl.sv
module dma_ai_ctrl
  import dma_ai_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] end_evt,
  input  logic [NCH-1:0] autoinit,
  output logic [DW-1:0]  ctrl_q
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = we ? wdata : ctrl_q;
    for (int c = 0; c < NCH; c++) begin
      if (end_evt[c] && !autoinit[c]) nxt[c] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= nxt;
  end
endmodule

// File: rtl/dma_autoinit_counter.sv
module dma_autoinit_counter
  import dma_ai_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_ch,
  input  logic [3:0]        cpu_fld,
  input  logic [15:0]       cpu_wdata,
  input  logic [NCH-1:0]    rd_done,
  input  logic [NCH-1:0]    wr_done,
  output logic [15:0]       ctrl_o,
  output logic [NCH*16-1:0] src_o,
  output logic [NCH*16-1:0] dst_o,
  output logic [NCH*16-1:0] elem_o,
  output logic [NCH*8-1:0]  frame_o,
  output logic [NCH-1:0]    frame_done_o,
  output logic [NCH-1:0]    block_done_o
);
  localparam int CHW = 3;

  rld_t [NCH-1:0] sel_rld;
  logic [NCH-1:0] end_vec;
  logic [NCH-1:0] ai_vec;
  logic [NCH-1:0] pend_vec;
  logic           ctrl_we;

  assign ctrl_we = cpu_we && cpu_fld == 4'(F_CTRL);

  dma_ai_ctrl #(.NCH(NCH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctrl_we),
    .wdata    (cpu_wdata),
    .end_evt  (end_vec),
    .autoinit (ai_vec),
    .ctrl_q   (ctrl_o)
  );

  dma_ai_reload_bank #(.NCH(NCH), .CHW(CHW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_ch    (cpu_ch),
    .cpu_fld   (cpu_fld),
    .cpu_wdata (cpu_wdata),
    .own_set   (ctrl_o[SEL_BIT]),
    .sel_rld   (sel_rld)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = cpu_we && cpu_ch == CHW'(c);
    dma_ai_chan u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (ctrl_o[c]),
      .rd_done      (rd_done[c]),
      .wr_done      (wr_done[c]),
      .we_src       (hit && cpu_fld == 4'(F_SRC)),
      .we_dst       (hit && cpu_fld == 4'(F_DST)),
      .we_cnt       (hit && cpu_fld == 4'(F_CNT)),
      .we_frm       (hit && cpu_fld == 4'(F_FRM)),
      .we_ai        (hit && cpu_fld == 4'(F_AUTO)),
      .wdata        (cpu_wdata),
      .rld          (sel_rld[c]),
      .src_q        (src_o[c*AW +: AW]),
      .dst_q        (dst_o[c*AW +: AW]),
      .elem_q       (elem_o[c*CW +: CW]),
      .frm_q        (frame_o[c*FW +: FW]),
      .frame_done_q (frame_done_o[c]),
      .block_done_q (block_done_o[c]),
      .end_evt      (end_vec[c]),
      .autoinit_q   (ai_vec[c]),
      .pend_q       (pend_vec[c])
    );
  end
endmodule

// File: rtl/dma_autoinit_chk.sv
module dma_autoinit_chk #(
  parameter int NCH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [NCH-1:0]    rd_done,
  input logic [NCH-1:0]    wr_done,
  input logic [15:0]       ctrl_o,
  input logic [NCH*16-1:0] src_o,
  input logic [NCH*16-1:0] dst_o,
  input logic [NCH*16-1:0] elem_o,
  input logic [NCH*8-1:0]  frame_o,
  input logic [NCH-1:0]    frame_done_o,
  input logic [NCH-1:0]    block_done_o,
  input logic [NCH-1:0]    ai_vec,
  input logic [NCH-1:0]    pend_vec
);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we && rd_done == '0 && wr_done == '0) |=>
      ($stable(src_o) && $stable(dst_o) && $stable(elem_o) && $stable(frame_o) && $stable(ctrl_o)));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R5
    block_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      block_done_o[c] |=> !block_done_o[c]);
    // R5
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_done_o[c] && block_done_o[c]));
    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (block_done_o[c] && !$past(ai_vec[c])) |-> !ctrl_o[c]);
    // R7
    auto_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (block_done_o[c] && $past(ai_vec[c]) && !$past(cpu_we)) |-> ctrl_o[c]);
    // R3
    elem_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[c] && !pend_vec[c] && rd_done[c] && elem_o[c*16 +: 16] != 16'd0 && !cpu_we) |=>
        (elem_o[c*16 +: 16] == $past(elem_o[c*16 +: 16]) - 16'd1));
  end
endmodule

bind dma_autoinit_counter dma_autoinit_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_we       (cpu_we),
  .rd_done      (rd_done),
  .wr_done      (wr_done),
  .ctrl_o       (ctrl_o),
  .src_o        (src_o),
  .dst_o        (dst_o),
  .elem_o       (elem_o),
  .frame_o      (frame_o),
  .frame_done_o (frame_done_o),
  .block_done_o (block_done_o),
  .ai_vec       (ai_vec),
  .pend_vec     (pend_vec)
);

// File: tb/sim_dma_autoinit_counter.sv
`timescale 1ns/1ps
module sim_dma_autoinit_counter;
  localparam int N = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cpu_we = 1'b0;
  logic [2:0]      cpu_ch = '0;
  logic [3:0]      cpu_fld = '0;
  logic [15:0]     cpu_wdata = '0;
  logic [N-1:0]    rd_done = '0;
  logic [N-1:0]    wr_done = '0;
  logic [15:0]     ctrl_o;
  logic [N*16-1:0] src_o, dst_o, elem_o;
  logic [N*8-1:0]  frame_o;
  logic [N-1:0]    frame_done_o, block_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  int m_src[N], m_dst[N], m_elem[N], m_init[N], m_frm[N];
  int m_ai[N], m_pend[N], m_fd[N], m_bd[N];
  int r_src[N], r_dst[N], r_cnt[N], r_frm[N];
  int m_ctrl;

  always #5 clk = ~clk;

  dma_autoinit_counter #(.NCH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_ch(cpu_ch), .cpu_fld(cpu_fld),
    .cpu_wdata(cpu_wdata), .rd_done(rd_done), .wr_done(wr_done), .ctrl_o(ctrl_o),
    .src_o(src_o), .dst_o(dst_o), .elem_o(elem_o), .frame_o(frame_o),
    .frame_done_o(frame_done_o), .block_done_o(block_done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int d_src(int c);   return int'(src_o[c*16 +: 16]);  endfunction
  function automatic int d_dst(int c);   return int'(dst_o[c*16 +: 16]);  endfunction
  function automatic int d_elem(int c);  return int'(elem_o[c*16 +: 16]); endfunction
  function automatic int d_frm(int c);   return int'(frame_o[c*8 +: 8]);  endfunction

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      m_src[c] = 0; m_dst[c] = 0; m_elem[c] = 0; m_init[c] = 0; m_frm[c] = 0;
      m_ai[c] = 0; m_pend[c] = 0; m_fd[c] = 0; m_bd[c] = 0;
      r_src[c] = 0; r_dst[c] = 0; r_cnt[c] = 0; r_frm[c] = 0;
    end
    m_ctrl = 0;
  endtask

  task automatic model_step();
    int d, f, ch, nctrl;
    d = int'(cpu_wdata); f = int'(cpu_fld); ch = int'(cpu_ch);
    nctrl = (cpu_we && f == 9) ? d : m_ctrl;
    for (int c = 0; c < N; c++) begin
      int s, rs, rd, rc, rf;
      bit en;
      en = m_ctrl[c];
      s  = m_ctrl[14] ? c : 0;
      rs = r_src[s]; rd = r_dst[s]; rc = r_cnt[s]; rf = r_frm[s];
      if (cpu_we && ch == s) begin
        if (f == 4) rs = d;
        if (f == 5) rd = d;
        if (f == 6) rc = d;
        if (f == 7) rf = d & 255;
      end
      m_fd[c] = 0; m_bd[c] = 0;
      if (en && m_pend[c] && wr_done[c]) begin
        m_bd[c] = 1; m_pend[c] = 0;
        if (m_ai[c]) begin
          m_src[c] = rs; m_dst[c] = rd; m_elem[c] = rc; m_init[c] = rc; m_frm[c] = rf;
        end else nctrl = nctrl & ~(1 << c);
      end else if (en && !m_pend[c] && rd_done[c]) begin
        if (m_elem[c] != 0) m_elem[c]--;
        else begin
          m_fd[c] = 1;
          if (m_frm[c] != 0) begin m_frm[c]--; m_elem[c] = m_init[c]; end
          else m_pend[c] = 1;
        end
      end
      if (cpu_we && ch == c) begin
        if (f == 0) m_src[c] = d;
        if (f == 1) m_dst[c] = d;
        if (f == 2) begin m_elem[c] = d; m_init[c] = d; end
        if (f == 3) m_frm[c] = d & 255;
        if (f == 8) m_ai[c] = d & 1;
      end
    end
    if (cpu_we && ch < N) begin
      if (f == 4) r_src[ch] = d;
      if (f == 5) r_dst[ch] = d;
      if (f == 6) r_cnt[ch] = d;
      if (f == 7) r_frm[ch] = d & 255;
    end
    m_ctrl = nctrl;
  endtask

  task automatic compare();
    chk(int'(ctrl_o) == m_ctrl, "R8 ctrl", int'(ctrl_o), m_ctrl);
    for (int c = 0; c < N; c++) begin
      chk(d_src(c) == m_src[c], "R7 src", d_src(c), m_src[c]);
      chk(d_dst(c) == m_dst[c], "R7 dst", d_dst(c), m_dst[c]);
      chk(d_elem(c) == m_elem[c], "R3 elem", d_elem(c), m_elem[c]);
      chk(d_frm(c) == m_frm[c], "R4 frame", d_frm(c), m_frm[c]);
      chk(int'(frame_done_o[c]) == m_fd[c], "R4 frame_done", int'(frame_done_o[c]), m_fd[c]);
      chk(int'(block_done_o[c]) == m_bd[c], "R5 block_done", int'(block_done_o[c]), m_bd[c]);
    end
  endtask

  // one clock with the currently driven inputs, then compare at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    cpu_we = 1'b0; rd_done = '0; wr_done = '0;
  endtask

  task automatic cw(input int fld, input int ch, input int data);
    cpu_we = 1'b1; cpu_fld = 4'(fld); cpu_ch = 3'(ch); cpu_wdata = 16'(data);
    tick();
  endtask

  task automatic strobe(input int c, input bit r, input bit w);
    rd_done[c] = r; wr_done[c] = w;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int fd_cnt;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_o == 16'h0 && src_o == '0 && dst_o == '0 && elem_o == '0 && frame_o == '0,
        "R1 reset regs", int'(ctrl_o), 0);
    chk(frame_done_o == '0 && block_done_o == '0, "R1 reset pulses", int'(block_done_o), 0);

    // R2 field writes, channel 1 one-shot: 3 elements x 2 frames
    cw(0, 1, 16'h1000); cw(1, 1, 16'h2000); cw(2, 1, 2); cw(3, 1, 1);
    chk(d_src(1) == 16'h1000 && d_dst(1) == 16'h2000, "R2 working write", d_src(1), 16'h1000);
    // R6 strobes ignored while disabled
    strobe(1, 1, 1);
    chk(d_elem(1) == 2, "R6 disabled channel ignores read", d_elem(1), 2);
    cw(9, 0, 16'h0002);
    // R6 write strobe ignored when not waiting
    strobe(1, 0, 1);
    chk(d_elem(1) == 2 && block_done_o[1] == 1'b0, "R6 early write-done", d_elem(1), 2);
    for (int i = 0; i < 6; i++) strobe(1, 1, 0);
    chk(d_frm(1) == 0 && d_elem(1) == 0, "R5 counters at end", d_frm(1), 0);
    strobe(1, 1, 0);  // ignored while waiting
    chk(d_elem(1) == 0 && frame_done_o[1] == 1'b0, "R5 read ignored while waiting", d_elem(1), 0);
    cw(9, 0, 16'h0002);  // same cycle as end below would be rewritten; here just hold
    cpu_we = 1'b1; cpu_fld = 4'd9; cpu_wdata = 16'h0002; wr_done[1] = 1'b1;
    tick();
    chk(block_done_o[1] == 1'b1, "R5 block_done", int'(block_done_o[1]), 1);
    chk(ctrl_o[1] == 1'b0, "R8 enable cleared over control write", int'(ctrl_o[1]), 0);
    tick();
    chk(block_done_o[1] == 1'b0, "R5 single-cycle pulse", int'(block_done_o[1]), 0);

    // R13 other control bits stored, no effect
    cw(9, 0, 16'hBFC0);
    chk(ctrl_o == 16'hBFC0, "R13 control readback", int'(ctrl_o), 16'hBFC0);
    cw(2, 3, 5);
    strobe(3, 1, 0);
    chk(d_elem(3) == 5, "R13 enables clear means no counting", d_elem(3), 5);

    // R9 shared set (bit14 = 0): channel 2 autoinit loads channel 0's set
    cw(4, 0, 16'hA0A0); cw(5, 0, 16'hB0B0); cw(6, 0, 1); cw(7, 0, 0);
    cw(4, 2, 16'hC2C2); cw(5, 2, 16'hD2D2); cw(6, 2, 3); cw(7, 2, 0);
    cw(8, 2, 1); cw(0, 2, 16'h0111); cw(2, 2, 1); cw(3, 2, 0);
    cw(9, 0, 16'h0004);
    strobe(2, 1, 0);
    // R10 reload write mid-block leaves working regs alone
    cw(4, 0, 16'hA1A1);
    chk(d_src(2) == 16'h0111 && d_elem(2) == 0, "R10 working untouched", d_src(2), 16'h0111);
    strobe(2, 1, 0);
    strobe(2, 0, 1);
    chk(d_src(2) == 16'hA1A1 && d_elem(2) == 1, "R9 shared set used", d_src(2), 16'hA1A1);
    chk(ctrl_o[2] == 1'b1, "R7 stays enabled", int'(ctrl_o[2]), 1);
    strobe(2, 1, 0);
    chk(d_elem(2) == 0, "R7 next block counts at once", d_elem(2), 0);

    // R9 own set (bit14 = 1) with R11 bypass on the ending cycle
    cw(9, 0, 16'h4004);
    strobe(2, 1, 0);
    cpu_we = 1'b1; cpu_fld = 4'd6; cpu_ch = 3'd2; cpu_wdata = 16'd7; wr_done[2] = 1'b1;
    tick();
    chk(d_src(2) == 16'hC2C2, "R9 own set used", d_src(2), 16'hC2C2);
    chk(d_elem(2) == 7, "R11 same-cycle reload write", d_elem(2), 7);

    // R12 CPU write beats a decrement
    cpu_we = 1'b1; cpu_fld = 4'd2; cpu_ch = 3'd2; cpu_wdata = 16'd40; rd_done[2] = 1'b1;
    tick();
    chk(d_elem(2) == 40, "R12 write wins over count", d_elem(2), 40);

    // R14 full 65536-read frame on channel 0
    cw(8, 0, 0); cw(2, 0, 16'hFFFF); cw(3, 0, 0); cw(9, 0, 16'h0001);
    fd_cnt = 0;
    for (int i = 0; i < 65536; i++) begin
      rd_done[0] = 1'b1;
      tick();
      if (frame_done_o[0]) fd_cnt++;
      if (i == 65534) chk(fd_cnt == 0 && d_elem(0) == 0, "R14 no frame end before 65536", fd_cnt, 0);
    end
    chk(fd_cnt == 1, "R14 frame end after 65536 reads", fd_cnt, 1);

    // random mix of all channels against the reference model
    for (int i = 0; i < 4000; i++) begin
      rd_done = 6'($urandom);
      wr_done = 6'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        cpu_we = 1'b1;
        cpu_ch = 3'($urandom_range(0, 5));
        cpu_fld = 4'($urandom_range(0, 9));
        cpu_wdata = (cpu_fld == 4'd9) ? 16'($urandom | 32'h3F) :
                    (cpu_fld == 4'd2 || cpu_fld == 4'd6) ? 16'($urandom_range(0, 4)) :
                    (cpu_fld == 4'd3 || cpu_fld == 4'd7) ? 16'($urandom_range(0, 2)) :
                    16'($urandom);
      end
      tick();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule